// File: doc/BRIEF.md
# Register-Triggered Word Copy Engine

This block moves a run of 32-bit words from one memory region to another without processor involvement. Software programs a source address, a destination address and a word count through a 32-byte register window. The write of the word count is itself the start command: no separate "go" bit exists. The engine then steps through memory one word at a time over a single-beat master port. It reads a word, optionally reverses its byte order, and writes it out. Both addresses advance by four bytes per word.

When the run ends, the engine zeroes the count register, sets a completion flag in the status byte and drives the interrupt line high. The line stays high until software acknowledges it through the control byte. A second function shares the window. A command register answers an identification query with a fixed code, or forwards an indirect read to a separate request/response port and files the returned word in a result register.

The registers are held little-endian while the host bus is big-endian. Every 32-bit access is therefore byte-reversed at the window: the value the engine uses is the bus word with its bytes reversed.

The copy controller has four states:
- `C_IDLE`: waits for a start.
- `C_READ`: a read beat on the memory port.
- `C_WRITE`: a write beat on the memory port.
- `C_DONE`: a single cycle that posts completion.

Its transitions:
- `C_IDLE` to `C_READ` on a start with a non-zero count.
- `C_IDLE` to `C_DONE` on a start with a zero count.
- `C_READ` to `C_WRITE` on a read acknowledge.
- `C_WRITE` to `C_READ` on a write acknowledge while words remain.
- `C_WRITE` to `C_DONE` on the acknowledge of the last word.
- `C_DONE` back to `C_IDLE`.

The query controller has two states: `Q_IDLE` and `Q_WAIT`. It moves from `Q_IDLE` to `Q_WAIT` on an indirect-read command, and back to `Q_IDLE` on the response acknowledge.

Top module: `word_dma_engine`

## Requirements
- R1: After reset all 32 window bytes read as zero, `irq` and `copy_busy` are low, and neither `mem_req` nor `qry_req` is asserted.
- R2: A 32-bit write with `reg_word`=1 to word offset W stores `reg_wdata[31:24]` at byte W, `reg_wdata[23:16]` at W+1, `reg_wdata[15:8]` at W+2 and `reg_wdata[7:0]` at W+3. A 32-bit read returns the bytes in that same order, and a byte read (`reg_word`=0) returns the byte in `reg_rdata[7:0]` with the upper bits zero. The engine uses the byte-reversed bus word as the register value.
- R3: A 32-bit write to offset 0x08 with value N (after reversal) starts a copy of N words. Word k is read from source+4k and written unchanged to destination+4k, with every beat held until `mem_ack`, and no other memory location is written.
- R4: If bit 7 of the config byte at offset 0x0E is set when the copy starts, each word is written with its four bytes in reverse order.
- R5: At the end of a copy the length register reads zero, bit 0 of the status byte at 0x0C reads one, and `irq` is high and stays high until that bit is cleared.
- R6: A byte write to offset 0x0D with bit 0 set clears status bit 0 and drops `irq`. A byte write there with bit 0 clear leaves `irq` high.
- R7: A length of zero completes with no memory beat and still sets the completion flag and `irq`.
- R8: `copy_busy` is high from the start of a copy until completion. A length write during that time is ignored and neither restarts nor extends the copy.
- R9: A 32-bit write to the command register at 0x10 whose value has bit 29 set loads the result register at 0x14 with 0x178611DB, read over the bus as 0xDB118617, and issues no query.
- R10: A command with bit 31 set and bit 29 clear issues one query at address 0x84000000 | command[7:0], holding `qry_req` until `qry_ack`. The word on `qry_rdata` is stored as the result value.
- R11: A 32-bit write to offset 0x14 sets the result register to 0xFFFFFFFF regardless of the data written.
- R12: A command with neither bit 29 nor bit 31 set changes no result and issues no query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| reg_addr | input | 5 | Byte offset inside the window |
| reg_wdata | input | 32 | Write data (byte writes use bits 7:0) |
| reg_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Completion interrupt, level of status bit 0 |
| copy_busy | output | 1 | Copy in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Beat completion |
| qry_req | output | 1 | Indirect read request |
| qry_addr | output | 32 | Indirect read address |
| qry_rdata | input | 32 | Indirect read data, valid with qry_ack |
| qry_ack | input | 1 | Indirect read completion |

## Verification
Copies are driven with random word counts from zero to twelve, random source and destination offsets and a random swap setting. A source pattern that depends on address and run number separates a correct copy from a stale or shifted one. Per-run write tags show overruns past the last word.

Directed cases cover the rest:
- a zero count, which separates the no-beat completion path from a one-word run;
- a length rewrite while busy, which tells an ignored write from a restart;
- commands with bit 29, bit 31, both or neither, which separate the identification, indirect and no-op paths.

// File: rtl/wdma_pkg.sv
package wdma_pkg;

    // Byte offsets inside the register window
    localparam int OFS_SRC  = 0;
    localparam int OFS_DST  = 4;
    localparam int OFS_LEN  = 8;
    localparam int OFS_STAT = 12;
    localparam int OFS_CTL  = 13;
    localparam int OFS_CFG  = 14;
    localparam int OFS_CMD  = 16;
    localparam int OFS_RES  = 20;

    // Bit positions with meaning
    localparam int CFG_SWAP_BIT = 7;
    localparam int CMD_ID_BIT   = 29;
    localparam int CMD_IND_BIT  = 31;

    typedef enum logic [1:0] {
        C_IDLE,
        C_READ,
        C_WRITE,
        C_DONE
    } copy_state_t;

    typedef enum logic {
        Q_IDLE,
        Q_WAIT
    } qry_state_t;

endpackage

// File: rtl/wdma_byte_rev.sv
module wdma_byte_rev #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int BYTES = DATA_W / 8;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end

endmodule

// File: rtl/wdma_copy_ctrl.sv
module wdma_copy_ctrl
    import wdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [LEN_W-1:0]  word_count,
    input  logic              swap_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);
    localparam logic [LEN_W-1:0]  ONE  = LEN_W'(1);

    copy_state_t       state_q, state_d;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [LEN_W-1:0]  left_q;
    logic              swap_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rdata_rev;

    wdma_byte_rev #(.DATA_W(DATA_W)) u_rev (
        .din  (mem_rdata),
        .dout (rdata_rev)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:  if (start) state_d = (word_count == '0) ? C_DONE : C_READ;
            C_READ:  if (mem_ack) state_d = C_WRITE;
            C_WRITE: if (mem_ack) state_d = (left_q == ONE) ? C_DONE : C_READ;
            C_DONE:  state_d = C_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = src_q;
        mem_wdata = data_q;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            C_IDLE:  busy = 1'b0;
            C_READ:  mem_req = 1'b1;
            C_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_q;
            end
            C_DONE:  done = 1'b1;
        endcase
    end

    // Datapath: working addresses, remaining count, held word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '0;
            swap_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (state_q == C_IDLE && start) begin
                src_q  <= src_base;
                dst_q  <= dst_base;
                left_q <= word_count;
                swap_q <= swap_en;
            end
            if (state_q == C_READ && mem_ack) begin
                data_q <= swap_q ? rdata_rev : mem_rdata;
            end
            if (state_q == C_WRITE && mem_ack) begin
                src_q  <= src_q + STEP;
                dst_q  <= dst_q + STEP;
                left_q <= left_q - ONE;
            end
        end
    end

endmodule

// File: rtl/wdma_query_ctrl.sv
module wdma_query_ctrl
    import wdma_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              DATA_W   = 32,
    parameter int              IDX_W    = 8,
    parameter logic [ADDR_W-1:0] IND_BASE = 32'h8400_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  index,
    output logic              qry_req,
    output logic [ADDR_W-1:0] qry_addr,
    input  logic [DATA_W-1:0] qry_rdata,
    input  logic              qry_ack,
    output logic              busy,
    output logic              load,
    output logic [DATA_W-1:0] load_data
);
    qry_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_IDLE: if (start) state_d = Q_WAIT;
            Q_WAIT: if (qry_ack) state_d = Q_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        qry_req   = 1'b0;
        busy      = 1'b0;
        load      = 1'b0;
        load_data = qry_rdata;
        qry_addr  = addr_q;
        unique case (state_q)
            Q_IDLE: ;
            Q_WAIT: begin
                qry_req = 1'b1;
                busy    = 1'b1;
                load    = qry_ack;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (state_q == Q_IDLE && start) begin
            addr_q <= IND_BASE | ADDR_W'(index);
        end
    end

endmodule

// File: rtl/word_dma_engine.sv
module word_dma_engine
    import wdma_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 32,
    parameter int                WIN_BYTES = 32,
    parameter logic [DATA_W-1:0] ID_CODE   = 32'h1786_11DB,
    parameter logic [ADDR_W-1:0] IND_BASE  = 32'h8400_0000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_word,
    input  logic [$clog2(WIN_BYTES)-1:0] reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    output logic                         irq,
    output logic                         copy_busy,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic [DATA_W-1:0]            mem_rdata,
    input  logic                         mem_ack,
    output logic                         qry_req,
    output logic [ADDR_W-1:0]            qry_addr,
    input  logic [DATA_W-1:0]            qry_rdata,
    input  logic                         qry_ack
);
    localparam int WIN_AW  = $clog2(WIN_BYTES);
    localparam int BYTES   = DATA_W / 8;
    localparam int LANE_AW = $clog2(BYTES);
    localparam int WSEL_W  = WIN_AW - LANE_AW;
    localparam int IDX_W   = 8;

    logic [7:0] regs_q [WIN_BYTES];
    logic [7:0] regs_d [WIN_BYTES];

    logic [WSEL_W-1:0] wsel;
    logic              word_wr, byte_wr;
    logic [DATA_W-1:0] bus_val;
    logic              hit_len, hit_cmd, hit_res;
    logic              len_blocked, copy_start, copy_done;
    logic              id_hit, qry_start, qry_busy, q_load;
    logic [DATA_W-1:0] q_data;
    logic              ack_clear;
    logic [ADDR_W-1:0] src_word, dst_word;

    assign wsel    = reg_addr[WIN_AW-1:LANE_AW];
    assign word_wr = reg_wr &  reg_word;
    assign byte_wr = reg_wr & ~reg_word;

    // Register value carried by a 32-bit bus write
    wdma_byte_rev #(.DATA_W(DATA_W)) u_bus_rev (
        .din  (reg_wdata),
        .dout (bus_val)
    );

    assign hit_len = word_wr && (int'(wsel) == OFS_LEN / BYTES);
    assign hit_cmd = word_wr && (int'(wsel) == OFS_CMD / BYTES);
    assign hit_res = word_wr && (int'(wsel) == OFS_RES / BYTES);

    assign len_blocked = hit_len &  copy_busy;
    assign copy_start  = hit_len & ~copy_busy;
    assign id_hit      = hit_cmd & bus_val[CMD_ID_BIT];
    assign qry_start   = hit_cmd & ~bus_val[CMD_ID_BIT] & bus_val[CMD_IND_BIT] & ~qry_busy;
    assign ack_clear   = byte_wr && (int'(reg_addr) == OFS_CTL) && reg_wdata[0];

    // Little-endian register words handed to the copy controller
    always_comb begin
        src_word = '0;
        dst_word = '0;
        for (int k = 0; k < BYTES; k++) begin
            src_word[8*k +: 8] = regs_q[WIN_AW'(OFS_SRC + k)];
            dst_word[8*k +: 8] = regs_q[WIN_AW'(OFS_DST + k)];
        end
    end

    // Next value of every window byte; later rules take priority
    always_comb begin
        for (int i = 0; i < WIN_BYTES; i++) begin
            regs_d[i] = regs_q[i];
            if (word_wr && (i / BYTES == int'(wsel)) &&
                !(len_blocked && (i / BYTES == OFS_LEN / BYTES))) begin
                regs_d[i] = reg_wdata[8*(BYTES-1-(i % BYTES)) +: 8];
            end
            if (byte_wr && (i == int'(reg_addr))) begin
                regs_d[i] = reg_wdata[7:0];
            end
            if (ack_clear && (i == OFS_STAT)) begin
                regs_d[i][0] = 1'b0;
            end
            if (i / BYTES == OFS_RES / BYTES) begin
                if (hit_res) regs_d[i] = 8'hFF;
                if (id_hit)  regs_d[i] = ID_CODE[8*(i % BYTES) +: 8];
                if (q_load)  regs_d[i] = q_data[8*(i % BYTES) +: 8];
            end
            if (copy_done && (i / BYTES == OFS_LEN / BYTES)) begin
                regs_d[i] = 8'h00;
            end
            if (copy_done && (i == OFS_STAT)) begin
                regs_d[i][0] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_BYTES; i++) regs_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < WIN_BYTES; i++) regs_q[i] <= regs_d[i];
        end
    end

    // Read path: big-endian word view or single byte
    always_comb begin
        reg_rdata = '0;
        if (reg_word) begin
            for (int k = 0; k < BYTES; k++) begin
                reg_rdata[8*(BYTES-1-k) +: 8] = regs_q[{wsel, LANE_AW'(k)}];
            end
        end else begin
            reg_rdata[7:0] = regs_q[reg_addr];
        end
    end

    assign irq = regs_q[WIN_AW'(OFS_STAT)][0];

    wdma_copy_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (DATA_W)
    ) u_copy (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (copy_start),
        .src_base   (src_word),
        .dst_base   (dst_word),
        .word_count (bus_val),
        .swap_en    (regs_q[WIN_AW'(OFS_CFG)][CFG_SWAP_BIT]),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .busy       (copy_busy),
        .done       (copy_done)
    );

    wdma_query_ctrl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .IND_BASE (IND_BASE)
    ) u_query (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (qry_start),
        .index     (bus_val[IDX_W-1:0]),
        .qry_req   (qry_req),
        .qry_addr  (qry_addr),
        .qry_rdata (qry_rdata),
        .qry_ack   (qry_ack),
        .busy      (qry_busy),
        .load      (q_load),
        .load_data (q_data)
    );

endmodule

// File: rtl/wdma_checker.sv
module wdma_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_word,
    input logic [4:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        irq,
    input logic        copy_busy,
    input logic        copy_done,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        qry_req,
    input logic [31:0] qry_addr,
    input logic        qry_ack
);
    logic ctl_clear;
    logic len_write;
    assign ctl_clear = reg_wr && !reg_word && (reg_addr == 5'h0D) && reg_wdata[0];
    assign len_write = reg_wr && reg_word && (reg_addr[4:2] == 3'd2);

    AST_MEM_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done |=> irq); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ctl_clear |=> irq); // R5

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clear && !copy_done |=> !irq); // R6

    AST_LEN_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        copy_busy && !copy_done && len_write |=> copy_busy); // R8

    AST_QRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        qry_req && !qry_ack |=> qry_req && $stable(qry_addr)); // R10

    AST_QRY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        qry_req |-> qry_addr[31:8] == 24'h840000); // R10

endmodule

bind word_dma_engine wdma_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_word  (reg_word),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .copy_busy (copy_busy),
    .copy_done (copy_done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .qry_req   (qry_req),
    .qry_addr  (qry_addr),
    .qry_ack   (qry_ack)
);

// File: tb/word_dma_engine_bench.sv
module word_dma_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_word = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, copy_busy;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        qry_req;
    logic [31:0] qry_addr;
    logic [31:0] qry_rdata = '0;
    logic        qry_ack = 1'b0;

    always #5 clk = ~clk;

    word_dma_engine u_word_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .copy_busy(copy_busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .qry_req(qry_req), .qry_addr(qry_addr),
        .qry_rdata(qry_rdata), .qry_ack(qry_ack)
    );

    int checks = 0;
    int failures = 0;
    int epoch = 0;
    int mem_beats = 0;
    int qry_count = 0;
    logic [31:0] last_qry_addr = '0;
    logic [31:0] wmem [256];
    int          wtag [256];

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] pat(input logic [31:0] a, input int e);
        return (a * 32'h9E37_79B1) ^ (32'(e) * 32'h7F4A_7C15) ^ 32'hC0DE_F00D;
    endfunction

    function automatic logic [31:0] qval(input logic [31:0] a);
        return a ^ 32'h5A5A_3C3C;
    endfunction

    // Memory model: one-cycle acknowledge, reads from a pattern, writes tagged by run
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_beats <= mem_beats + 1;
            if (mem_we) begin
                wmem[mem_addr[9:2]] <= mem_wdata;
                wtag[mem_addr[9:2]] <= epoch;
            end else begin
                mem_rdata <= pat(mem_addr, epoch);
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Indirect read responder
    always @(posedge clk) begin
        if (qry_req && !qry_ack) begin
            qry_ack <= 1'b1;
            qry_rdata <= qval(qry_addr);
            last_qry_addr <= qry_addr;
            qry_count <= qry_count + 1;
        end else begin
            qry_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_word = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_byte(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_word = 1'b0; reg_addr = a; reg_wdata = {24'h0, d};
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_word(input logic [4:0] a, output logic [31:0] d);
        reg_word = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_byte(input logic [4:0] a, output logic [31:0] d);
        reg_word = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if (irq) begin seen = 1'b1; break; end
        end
    endtask

    // One copy, checked word by word against the bench pattern
    task automatic run_copy(input logic [31:0] src, input logic [31:0] dst, input int len, input bit swap);
        logic [31:0] v, exp;
        int beats0;
        bit seen;
        epoch++;
        wr_byte(5'h0E, swap ? 8'h80 : 8'h00);
        wr_word(5'h00, bswap(src));
        wr_word(5'h04, bswap(dst));
        beats0 = mem_beats;
        wr_word(5'h08, bswap(32'(len)));
        wait_irq(seen);
        check(seen, "R5 irq after copy", 32'(irq), 32'h1);
        for (int w = 0; w < len; w++) begin
            exp = pat(src + 32'(4*w), epoch);
            if (swap) exp = bswap(exp); // R4
            v = wmem[8'((dst + 32'(4*w)) >> 2)];
            check(wtag[8'((dst + 32'(4*w)) >> 2)] == epoch && v == exp,
                  swap ? "R4 swapped word" : "R3 copied word", v, exp);
        end
        check(wtag[8'((dst + 32'(4*len)) >> 2)] != epoch, "R3 no overrun",
              32'(wtag[8'((dst + 32'(4*len)) >> 2)]), 32'(epoch));
        check(mem_beats - beats0 == 2*len, len == 0 ? "R7 zero-length beats" : "R3 beat count",
              32'(mem_beats - beats0), 32'(2*len));
        rd_word(5'h08, v);
        check(v == 32'h0, "R5 length cleared", v, 32'h0);
        rd_byte(5'h0C, v);
        check(v[0] == 1'b1, "R5 status bit", v, 32'h1);
        wr_byte(5'h0D, 8'h01);
        check(irq == 1'b0, "R6 acknowledge clears irq", 32'(irq), 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        bit seen;
        int qc0, beats0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            wtag[i] = 0;
            wmem[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 32; a += 4) begin
            rd_word(5'(a), v);
            check(v == 32'h0, "R1 reset window", v, 32'h0);
        end
        check(!irq && !copy_busy && !mem_req && !qry_req, "R1 reset outputs",
              {28'h0, irq, copy_busy, mem_req, qry_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: byte lanes of a 32-bit write
        wr_word(5'h00, 32'hA1B2_C3D4);
        rd_byte(5'h00, v); check(v == 32'h0000_00A1, "R2 byte 0", v, 32'hA1);
        rd_byte(5'h03, v); check(v == 32'h0000_00D4, "R2 byte 3", v, 32'hD4);
        rd_word(5'h00, v); check(v == 32'hA1B2_C3D4, "R2 word readback", v, 32'hA1B2C3D4);

        // Directed copies
        run_copy(32'h0000_0040, 32'h0000_0200, 4, 1'b0);
        run_copy(32'h0000_0080, 32'h0000_0280, 3, 1'b1);
        run_copy(32'h0000_0010, 32'h0000_0300, 1, 1'b0);
        run_copy(32'h0000_0010, 32'h0000_0300, 0, 1'b0); // R7

        // R6: clear bit low has no effect
        run_copy(32'h0000_0020, 32'h0000_0240, 0, 1'b0);
        epoch++;
        wr_word(5'h08, 32'h0);
        wait_irq(seen);
        wr_byte(5'h0D, 8'h02);
        check(irq == 1'b1, "R6 bit0 clear write ignored", 32'(irq), 32'h1);
        wr_byte(5'h0D, 8'h01);

        // R8: length write during a copy is ignored
        epoch++;
        wr_byte(5'h0E, 8'h00);
        wr_word(5'h00, bswap(32'h0000_0100));
        wr_word(5'h04, bswap(32'h0000_0380));
        beats0 = mem_beats;
        wr_word(5'h08, bswap(32'd6));
        @(negedge clk);
        check(copy_busy == 1'b1, "R8 busy during copy", 32'(copy_busy), 32'h1);
        wr_word(5'h08, bswap(32'd2));
        rd_word(5'h08, v);
        check(v == bswap(32'd6), "R8 blocked length write", v, bswap(32'd6));
        wait_irq(seen);
        check(mem_beats - beats0 == 12, "R8 no restart", 32'(mem_beats - beats0), 32'd12);
        wr_byte(5'h0D, 8'h01);
        repeat (10) @(negedge clk);
        check(!copy_busy && !irq, "R8 idle after copy", {30'h0, copy_busy, irq}, 32'h0);

        // Random copies
        for (int r = 0; r < 10; r++) begin
            run_copy(32'h1000_0000 + 32'(($urandom % 64) * 4),
                     32'h1000_0200 + 32'(($urandom % 64) * 4),
                     int'($urandom % 13), 1'($urandom % 2));
        end

        // R9: identification
        qc0 = qry_count;
        wr_word(5'h10, bswap(32'h2000_0000));
        rd_word(5'h14, v);
        check(v == 32'hDB11_8617, "R9 identifier", v, 32'hDB118617);
        wr_word(5'h10, bswap(32'hA000_0011));
        repeat (4) @(negedge clk);
        rd_word(5'h14, v);
        check(v == 32'hDB11_8617 && qry_count == qc0, "R9 bit 29 wins", v, 32'hDB118617);

        // R11: result write
        wr_word(5'h14, 32'h1234_5678);
        rd_word(5'h14, v);
        check(v == 32'hFFFF_FFFF, "R11 result all ones", v, 32'hFFFFFFFF);

        // R12: no-op command
        wr_word(5'h10, bswap(32'h0000_0005));
        repeat (4) @(negedge clk);
        rd_word(5'h14, v);
        check(v == 32'hFFFF_FFFF && qry_count == qc0, "R12 no-op command", v, 32'hFFFFFFFF);

        // R10: indirect read
        wr_word(5'h10, bswap(32'h8000_00AB));
        for (int c = 0; c < 100 && qry_count == qc0; c++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(last_qry_addr == 32'h8400_00AB, "R10 query address", last_qry_addr, 32'h840000AB);
        rd_word(5'h14, v);
        check(v == bswap(qval(32'h8400_00AB)), "R10 query result", v, bswap(qval(32'h8400_00AB)));
        check(qry_count == qc0 + 1, "R10 single query", 32'(qry_count), 32'(qc0 + 1));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

endmodule